// File: doc/BRIEF.md
# Parallel Bus Mailbox Port

This block is the slave side of an 8-bit parallel backplane port. A host CPU sees two byte-wide I/O registers on the backplane: a data register and a read-only status register. Through them it exchanges single bytes with a local controller. There is one byte mailbox for each direction. The host polls two flags: one says a byte is waiting for the host, the other says the local side can accept a new byte.

The base address comes from an 8-position DIP switch. Seven positions set the upper seven address bits, so the port can only sit on an even base address. The remaining position chooses whether the M1 bus signal qualifies accesses. Whenever either flag rises, the block raises a fixed-width interrupt pulse, and an enable input gates that pulse onto the bus line. On the local side a controller pushes outgoing bytes and pops incoming bytes with simple strobes.

After reset the local side needs a short initialisation period before it reports itself ready to accept bytes.

Top module: `mbox_port`

## Requirements
- R1: An access is selected only when addr_i[7:1] equals the bitwise complement of dip_on_i[7:1] (a switch that is ON, value 1, selects address bit 0). An unselected access changes no state, keeps host_oe_o at 0 and returns 00h on host_data_o.
- R2: When dip_on_i[0] is 1, an access is selected only while m1_i is 0. When dip_on_i[0] is 0, m1_i has no effect.
- R3: A selected read with addr_i[0]=0 returns the outgoing mailbox byte on host_data_o in the same cycle and clears the byte-for-host flag at the next clock edge.
- R4: A selected write with addr_i[0]=0 while the ready-to-accept flag is 1 latches host_data_i, clears that flag and sets lcl_valid_o. Such a write while the flag is 0 is ignored.
- R5: A selected read with addr_i[0]=1 returns the status byte: bit 7 is the byte-for-host flag, bit 6 is the ready-to-accept flag, and bits 5..0 are 0. A write to that address has no effect.
- R6: lcl_push_i while lcl_ready_o is 1 stores lcl_pdata_i and sets the byte-for-host flag. A push while that flag is 1 is refused, and the stored byte is kept.
- R7: lcl_pop_i while lcl_valid_o is 1 clears lcl_valid_o and sets the ready-to-accept flag again. lcl_rdata_o holds the byte the host wrote.
- R8: After reset the status reads 00h for INIT_CYC clock edges. After that it reads 40h.
- R9: A rise of either flag drives irq_o high from the following cycle for PULSE_NS of clock time (500 cycles at the default parameters).
- R10: While irq_en_i is 0, irq_o stays 0.
- R11: host_oe_o is 1 exactly in cycles that carry a selected read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Host I/O address |
| rd_i | input | 1 | Host read strobe, one cycle per access |
| wr_i | input | 1 | Host write strobe, one cycle per access |
| m1_i | input | 1 | Bus M1 signal, active high |
| dip_on_i | input | 8 | DIP positions, 1 = ON; bit 0 enables M1 qualification |
| host_data_i | input | 8 | Host write data |
| host_data_o | output | 8 | Host read data |
| host_oe_o | output | 1 | Read data drive enable |
| irq_en_i | input | 1 | Gates the interrupt pulse onto irq_o |
| irq_o | output | 1 | Interrupt request pulse |
| lcl_push_i | input | 1 | Local push strobe |
| lcl_pdata_i | input | 8 | Local byte to send to the host |
| lcl_ready_o | output | 1 | Outgoing mailbox empty |
| lcl_pop_i | input | 1 | Local pop strobe |
| lcl_rdata_o | output | 8 | Byte written by the host |
| lcl_valid_o | output | 1 | Incoming mailbox holds a byte |

## Verification
A flag in the wrong state is visible at the next status read. A stuck byte-for-host flag also shows at once as a refused local push. A wrong mailbox byte shows as a scoreboard mismatch on the next host read or local pop. A decode fault shows as host_oe_o in the wrong cycle or as a write that lands when it should not. An interrupt counter that is loaded wrongly shows as a pulse of the wrong length, which the bench measures cycle by cycle.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int OBF_BIT = 7;
  localparam int IBF_BIT = 6;

  typedef struct packed {
    logic rd_data;
    logic rd_stat;
    logic wr_data;
    logic wr_stat;
  } host_op_t;
endpackage

// File: rtl/mbox_addr_dec.sv
module mbox_addr_dec
  import mbox_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              m1_i,
  input  logic [ADDR_W-1:0] dip_on_i,
  output host_op_t          op_o
);
  localparam int SEL_W = ADDR_W - 1;

  logic [SEL_W-1:0] base_bits;
  logic             hit;

  // switch ON pulls its address bit low
  assign base_bits = ~dip_on_i[ADDR_W-1:1];
  assign hit = (addr_i[ADDR_W-1:1] == base_bits) && (!dip_on_i[0] || !m1_i);

  always_comb begin
    op_o.rd_data = hit && rd_i && !addr_i[0];
    op_o.rd_stat = hit && rd_i &&  addr_i[0];
    op_o.wr_data = hit && wr_i && !addr_i[0];
    op_o.wr_stat = hit && wr_i &&  addr_i[0];
  end
endmodule

// File: rtl/mbox_flags.sv
module mbox_flags #(
  parameter int DATA_W   = 8,
  parameter int INIT_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_wr_i,
  input  logic              host_rd_i,
  input  logic [DATA_W-1:0] host_data_i,
  input  logic              lcl_push_i,
  input  logic [DATA_W-1:0] lcl_pdata_i,
  input  logic              lcl_pop_i,
  output logic              obf_o,
  output logic              ibf_o,
  output logic              in_full_o,
  output logic [DATA_W-1:0] out_byte_o,
  output logic [DATA_W-1:0] in_byte_o
);
  localparam int INIT_W = $clog2(INIT_CYC + 1);

  logic [INIT_W-1:0] init_cnt;
  logic              init_done;

  assign init_done = (init_cnt == INIT_W'(INIT_CYC));
  assign ibf_o     = init_done && !in_full_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        init_cnt <= '0;
    else if (!init_done) init_cnt <= init_cnt + 1'b1;
  end

  // host -> local mailbox
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_full_o <= 1'b0;
      in_byte_o <= '0;
    end else if (host_wr_i && ibf_o) begin
      in_full_o <= 1'b1;
      in_byte_o <= host_data_i;
    end else if (lcl_pop_i && in_full_o) begin
      in_full_o <= 1'b0;
    end
  end

  // local -> host mailbox; push wins only when empty
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      obf_o      <= 1'b0;
      out_byte_o <= '0;
    end else if (lcl_push_i && !obf_o) begin
      obf_o      <= 1'b1;
      out_byte_o <= lcl_pdata_i;
    end else if (host_rd_i) begin
      obf_o      <= 1'b0;
    end
  end
endmodule

// File: rtl/mbox_irq_pulse.sv
module mbox_irq_pulse #(
  parameter int PULSE_CYC = 500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic obf_i,
  input  logic ibf_i,
  input  logic en_i,
  output logic irq_o
);
  localparam int CNT_W = $clog2(PULSE_CYC + 1);

  logic             obf_q, ibf_q, rise;
  logic [CNT_W-1:0] cnt;

  assign rise = (obf_i && !obf_q) || (ibf_i && !ibf_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      obf_q <= 1'b0;
      ibf_q <= 1'b0;
      cnt   <= '0;
    end else begin
      obf_q <= obf_i;
      ibf_q <= ibf_i;
      if (rise)          cnt <= CNT_W'(PULSE_CYC);
      else if (cnt != 0) cnt <= cnt - 1'b1;
    end
  end

  assign irq_o = en_i && (cnt != 0);
endmodule

// File: rtl/mbox_port.sv
module mbox_port
  import mbox_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int INIT_CYC = 4,
  parameter int CLK_KHZ  = 100_000,
  parameter int PULSE_NS = 5000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              m1_i,
  input  logic [ADDR_W-1:0] dip_on_i,
  input  logic [DATA_W-1:0] host_data_i,
  output logic [DATA_W-1:0] host_data_o,
  output logic              host_oe_o,
  input  logic              irq_en_i,
  output logic              irq_o,
  input  logic              lcl_push_i,
  input  logic [DATA_W-1:0] lcl_pdata_i,
  output logic              lcl_ready_o,
  input  logic              lcl_pop_i,
  output logic [DATA_W-1:0] lcl_rdata_o,
  output logic              lcl_valid_o
);
  localparam int PULSE_CYC = (CLK_KHZ * PULSE_NS) / 1_000_000;

  host_op_t          op;
  logic              obf, ibf, in_full;
  logic [DATA_W-1:0] out_byte, status;

  mbox_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i   (addr_i),
    .rd_i     (rd_i),
    .wr_i     (wr_i),
    .m1_i     (m1_i),
    .dip_on_i (dip_on_i),
    .op_o     (op)
  );

  mbox_flags #(.DATA_W(DATA_W), .INIT_CYC(INIT_CYC)) u_flags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .host_wr_i   (op.wr_data),
    .host_rd_i   (op.rd_data),
    .host_data_i (host_data_i),
    .lcl_push_i  (lcl_push_i),
    .lcl_pdata_i (lcl_pdata_i),
    .lcl_pop_i   (lcl_pop_i),
    .obf_o       (obf),
    .ibf_o       (ibf),
    .in_full_o   (in_full),
    .out_byte_o  (out_byte),
    .in_byte_o   (lcl_rdata_o)
  );

  mbox_irq_pulse #(.PULSE_CYC(PULSE_CYC)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .obf_i  (obf),
    .ibf_i  (ibf),
    .en_i   (irq_en_i),
    .irq_o  (irq_o)
  );

  always_comb begin
    status          = '0;
    status[OBF_BIT] = obf;
    status[IBF_BIT] = ibf;
  end

  assign host_oe_o   = op.rd_data || op.rd_stat;
  assign host_data_o = op.rd_data ? out_byte : (op.rd_stat ? status : '0);
  assign lcl_ready_o = !obf;
  assign lcl_valid_o = in_full;
endmodule

// File: rtl/mbox_port_chk.sv
module mbox_port_chk
  import mbox_pkg::*;
(
  input logic     clk_i,
  input logic     rst_ni,
  input host_op_t op,
  input logic     obf,
  input logic     ibf,
  input logic     lcl_push_i,
  input logic     irq_en_i,
  input logic     irq_o,
  input logic     host_oe_o,
  input logic [7:0] host_data_o
);
  a_r3_read_clears_obf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op.rd_data && obf) |=> !obf);

  a_r4_write_clears_ibf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op.wr_data && ibf) |=> !ibf);

  a_r6_push_refused: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lcl_push_i && obf && !op.rd_data) |=> obf);

  a_r9_irq_after_obf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(obf) && irq_en_i) |=> (irq_o || !irq_en_i));

  a_r10_irq_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_i |-> !irq_o);

  a_r5_status_layout: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op.rd_stat |-> (host_data_o == {obf, ibf, 6'b0}));

  a_r11_idle_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !host_oe_o |-> (host_data_o == 8'h00));
endmodule

bind mbox_port mbox_port_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .op          (op),
  .obf         (obf),
  .ibf         (ibf),
  .lcl_push_i  (lcl_push_i),
  .irq_en_i    (irq_en_i),
  .irq_o       (irq_o),
  .host_oe_o   (host_oe_o),
  .host_data_o (host_data_o)
);

// File: tb/sim_mbox_port.sv
`timescale 1ns/1ps
module sim_mbox_port;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] addr_i = '0;
  logic       rd_i = 1'b0, wr_i = 1'b0, m1_i = 1'b0;
  logic [7:0] dip_on_i = 8'hCA;   // base 34h, M1 qualification off
  logic [7:0] host_data_i = '0;
  logic [7:0] host_data_o;
  logic       host_oe_o;
  logic       irq_en_i = 1'b1;
  logic       irq_o;
  logic       lcl_push_i = 1'b0;
  logic [7:0] lcl_pdata_i = '0;
  logic       lcl_ready_o;
  logic       lcl_pop_i = 1'b0;
  logic [7:0] lcl_rdata_o;
  logic       lcl_valid_o;

  localparam logic [7:0] BASE = 8'h34;
  localparam int PULSE = 500;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  logic [7:0] exp_out_q[$];
  logic [7:0] exp_in_q[$];

  always #5 clk_i = ~clk_i;

  mbox_port u0 (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one read cycle; returns data and oe sampled mid-cycle
  task automatic host_rd(input logic [7:0] a, output logic [7:0] d, output logic oe);
    @(negedge clk_i); addr_i = a; rd_i = 1'b1;
    #1; d = host_data_o; oe = host_oe_o;
    @(negedge clk_i); rd_i = 1'b0;
  endtask

  task automatic host_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk_i); addr_i = a; host_data_i = d; wr_i = 1'b1;
    @(negedge clk_i); wr_i = 1'b0;
  endtask

  // driver: push expected byte when the block accepts it
  task automatic lcl_push(input logic [7:0] d, input bit expect_ok);
    @(negedge clk_i); lcl_pdata_i = d; lcl_push_i = 1'b1;
    #1; chk(lcl_ready_o == expect_ok, "R6 ready", lcl_ready_o, expect_ok);
    if (expect_ok) exp_out_q.push_back(d);
    @(negedge clk_i); lcl_push_i = 1'b0;
  endtask

  // monitor side for host reads of the data register
  task automatic host_rd_data_chk();
    logic [7:0] d; logic oe; logic [7:0] e;
    host_rd(BASE, d, oe);
    e = (exp_out_q.size() != 0) ? exp_out_q.pop_front() : 8'hxx;
    chk(oe && d === e, "R3 data read", d, e);
  endtask

  task automatic lcl_pop_chk();
    logic [7:0] e;
    @(negedge clk_i);
    e = (exp_in_q.size() != 0) ? exp_in_q.pop_front() : 8'hxx;
    chk(lcl_valid_o && lcl_rdata_o === e, "R7 pop data", lcl_rdata_o, e);
    lcl_pop_i = 1'b1;
    @(negedge clk_i); lcl_pop_i = 1'b0;
  endtask

  task automatic stat_chk(input logic [7:0] e, input string req);
    logic [7:0] d; logic oe;
    host_rd(BASE + 8'h1, d, oe);
    chk(oe && d == e, req, d, e);
  endtask

  task automatic irq_width(output int w);
    int wait_c = 0;
    w = 0;
    while (!irq_o && wait_c < 20) begin @(negedge clk_i); wait_c++; end
    while (irq_o && w < 2000) begin w++; @(negedge clk_i); end
  endtask

  initial begin
    logic [7:0] d; logic oe; int w;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R8: init window
    stat_chk(8'h00, "R8 status during init");
    // R9: ready flag rising after init gives one pulse
    irq_width(w);
    chk(w == PULSE, "R9 pulse width after init", w, PULSE);
    stat_chk(8'h40, "R8 status after init");

    // R1: wrong address ignored
    host_rd(8'h36, d, oe);
    chk(!oe && d == 8'h00, "R1 unselected read", {oe, d}, 0);
    host_wr(8'h36, 8'h99);
    #1; chk(!lcl_valid_o, "R1 unselected write", lcl_valid_o, 0);
    host_rd(8'h35 ^ 8'h80, d, oe);
    chk(!oe, "R11 oe on miss", oe, 0);

    // R5: write to status ignored
    host_wr(BASE + 8'h1, 8'hFF);
    #1; chk(!lcl_valid_o, "R5 status write ignored", lcl_valid_o, 0);
    stat_chk(8'h40, "R5 status unchanged");

    // R4 / R7: host to local, second write while full ignored
    host_wr(BASE, 8'hA5); exp_in_q.push_back(8'hA5);
    stat_chk(8'h00, "R4 ready flag cleared");
    host_wr(BASE, 8'h5A);
    lcl_pop_chk();
    #1; chk(!lcl_valid_o, "R7 valid cleared", lcl_valid_o, 0);
    stat_chk(8'h40, "R7 ready flag set again");

    // R6 / R3: local to host, push while full refused
    lcl_push(8'h3C, 1'b1);
    stat_chk(8'hC0, "R5 status both flags");
    lcl_push(8'hE7, 1'b0);
    host_rd_data_chk();
    stat_chk(8'h40, "R3 byte flag cleared");
    irq_width(w);   // pulse from the push, already partly elapsed
    chk(w > 0 && w < PULSE, "R9 pulse from push present", w, PULSE);

    // R9: full pulse measured from a fresh push
    repeat (5) @(negedge clk_i);
    lcl_push(8'h11, 1'b1);
    irq_width(w);
    chk(w == PULSE, "R9 pulse width after push", w, PULSE);
    host_rd_data_chk();
    repeat (PULSE + 5) @(negedge clk_i);

    // R10: gated
    irq_en_i = 1'b0;
    lcl_push(8'h22, 1'b1);
    begin
      bit seen = 0;
      repeat (PULSE + 10) begin @(negedge clk_i); if (irq_o) seen = 1; end
      chk(!seen, "R10 irq gated", seen, 0);
    end
    host_rd_data_chk();
    repeat (PULSE + 5) @(negedge clk_i);
    irq_en_i = 1'b1;

    // R2: M1 qualification
    dip_on_i = 8'hCB;
    m1_i = 1'b1;
    host_rd(BASE + 8'h1, d, oe);
    chk(!oe, "R2 M1 blocks access", oe, 0);
    m1_i = 1'b0;
    host_rd(BASE + 8'h1, d, oe);
    chk(oe && d == 8'h40, "R2 access without M1", d, 8'h40);
    dip_on_i = 8'hCA; m1_i = 1'b1;
    host_rd(BASE + 8'h1, d, oe);
    chk(oe && d == 8'h40, "R2 M1 ignored when off", d, 8'h40);
    m1_i = 1'b0;

    // R1: another base via switches (base 0Ah)
    dip_on_i = ~8'h0A;
    dip_on_i[0] = 1'b0;
    host_rd(8'h0B, d, oe);
    chk(oe && d == 8'h40, "R1 other base", d, 8'h40);
    host_rd(8'h0C, d, oe);
    chk(!oe, "R1 neighbour miss", oe, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100_000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule